// File: doc/BRIEF.md
# Gated Frequency and Period Measurement Counter

This block measures an external signal in one of three ways. In frequency mode it counts rising edges of either a fast input or a slow input while a gate of a selectable number of millisecond ticks is open. The fast input is halved before counting, so its result is half the edge count. In period mode it counts cycles of a reference timebase, nominally 900 kHz and delivered as a one-cycle strobe, across one or two complete periods of the slow input. Each mode first waits a fixed number of millisecond ticks after the control write, so that the input can settle before measurement starts.

Control is written as a word of fields that is captured on a one-cycle latch strobe. A write with the run bit clear stops and zeroes the counter. A write with the run bit set starts a new measurement on top of the present value, so repeated writes add several measurements together. The result is held when a measurement finishes, and a completion flag is raised. The count saturates at its all-ones value and sets a sticky overflow flag. Both input pins are also brought out as synchronized levels, so that either can be read as a plain input.

Top module: `freq_period_meter`

## Requirements
- R1: Source selection is taken at the latch strobe. `selHigh`=1 selects fast-input frequency mode. `selHigh`=0 with `selFreq`=1 selects slow-input frequency mode. Both at 0 select slow-input period mode. The pin that is not selected has no effect on the count.
- R2: In fast-input frequency mode, every second rising edge inside the gate adds one to the count, so the result is floor(edges/2). The halving divider restarts at each latch strobe.
- R3: In frequency mode, `gateSel` values 0, 1, 2 and 3 give gates of 4, 8, 32 and 64 `msTick` pulses. The gate opens after the settling wait. `done` rises in the cycle after the last gate tick.
- R4: In period mode, `gateSel[0]`=0 measures one slow-input period and 1 measures two. The first rising edge after the wait opens the window. From the cycle after that edge, up to and including the closing edge, each cycle with `refTick` high adds one.
- R5: The settling wait is 4 `msTick` pulses after the latch, or 8 in two-period mode. Input edges during the wait are not counted.
- R6: A latch strobe with `countEn`=0 zeroes the count and clears `done` and `overflow` by the next cycle. The block then stays idle.
- R7: A latch strobe with `countEn`=1 restarts the wait without clearing the count. The new measurement is added to the earlier value.
- R8: `done` is 0 from the latch strobe until the measurement ends, then stays 1 until the next strobe. While `done` is 1 the count does not change.
- R9: The count never wraps. An increment at the all-ones value leaves the count there and sets `overflow`, which stays set until a clearing write.
- R10: `fastLevel` and `slowLevel` follow their pins through two flip-flops, so they change two rising clock edges after the pin changes.
- R11: Only rising edges are counted. A level that is already high when the gate opens is not an edge, and neither is a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fastIn | input | 1 | Fast measured input, asynchronous |
| slowIn | input | 1 | Slow measured input, asynchronous |
| refTick | input | 1 | Reference timebase strobe for period mode |
| msTick | input | 1 | One-cycle strobe each millisecond |
| ctrlLatch | input | 1 | Captures the control fields below |
| selHigh | input | 1 | Selects fast-input frequency mode |
| selFreq | input | 1 | With selHigh=0: 1 frequency, 0 period |
| countEn | input | 1 | 1 starts or accumulates, 0 clears |
| gateSel | input | 2 | Gate time, or period count in bit 0 |
| count | output | CNT_W (20) | Measurement result |
| done | output | 1 | Measurement complete |
| overflow | output | 1 | Count reached saturation |
| fastLevel | output | 1 | Synchronized fast pin level |
| slowLevel | output | 1 | Synchronized slow pin level |

## Verification
The state machine decides which cycles count, so a wrong state shows up as a count off by whole edges or whole reference cycles. A wrong tick length shows up as `done` rising one millisecond tick early or late. The stimulus keeps every edge clear of the gate boundaries, and it checks `done` one tick before and at the gate end, so the exact state on every cycle is visible. A divider or accumulation fault shows up as a wrong result on the next completed measurement. A saturation fault shows up when the count is pushed to exactly the all-ones value and then one count past it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    SRC_FAST   = 2'd0,
    SRC_SLOW   = 2'd1,
    SRC_PERIOD = 2'd2
  } srcMode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_ARM  = 3'd2,
    ST_GATE = 3'd3,
    ST_DONE = 3'd4
  } measState_e;

  // strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic clearAll;
    logic restart;
    logic cntFast;
    logic cntSlow;
    logic cntRef;
  } dpCtrl_t;

endpackage

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastIn,
  input  logic             slowIn,
  input  logic             refTick,
  input  dpCtrl_t          dp,
  output logic             slowRise,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             fastLevel,
  output logic             slowLevel
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] fastSync;
  logic [1:0] slowSync;
  logic       fastPrev;
  logic       slowPrev;
  logic       halfTgl;
  logic       fastRise;
  logic       incr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastSync <= '0;
      slowSync <= '0;
      fastPrev <= 1'b0;
      slowPrev <= 1'b0;
    end else begin
      fastSync <= {fastSync[0], fastIn};
      slowSync <= {slowSync[0], slowIn};
      fastPrev <= fastSync[1];
      slowPrev <= slowSync[1];
    end
  end

  assign fastRise  = fastSync[1] & ~fastPrev;
  assign slowRise  = slowSync[1] & ~slowPrev;
  assign fastLevel = fastSync[1];
  assign slowLevel = slowSync[1];

  // divide-by-two on the fast path, advancing only while it is counted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     halfTgl <= 1'b0;
    else if (dp.restart)           halfTgl <= 1'b0;
    else if (dp.cntFast && fastRise) halfTgl <= ~halfTgl;
  end

  assign incr = (dp.cntFast & fastRise & halfTgl)
              | (dp.cntSlow & slowRise)
              | (dp.cntRef  & refTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (dp.clearAll) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (incr) begin
      if (count == CNT_MAX) overflow <= 1'b1;
      else                  count    <= count + 1'b1;
    end
  end

endmodule

// File: rtl/fpm_control.sv
module fpm_control
  import fpm_pkg::*;
#(
  parameter int WAIT_SHORT = 4,
  parameter int WAIT_LONG  = 8,
  parameter int GATE_T0    = 4,
  parameter int GATE_T1    = 8,
  parameter int GATE_T2    = 32,
  parameter int GATE_T3    = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlLatch,
  input  logic       selHigh,
  input  logic       selFreq,
  input  logic       countEn,
  input  logic [1:0] gateSel,
  input  logic       msTick,
  input  logic       slowRise,
  output dpCtrl_t    dp,
  output logic       done
);

  localparam int TW = $clog2(GATE_T3 + WAIT_LONG + 2);

  measState_e     state;
  srcMode_e       mode;
  logic [1:0]     gsel;
  logic [TW-1:0]  tickCnt;
  logic           edgeSeen;
  logic [TW-1:0]  waitLen;
  logic [TW-1:0]  gateLen;
  logic           twoPeriods;

  assign twoPeriods = gsel[0];

  always_comb begin
    waitLen = (mode == SRC_PERIOD && twoPeriods) ? TW'(WAIT_LONG) : TW'(WAIT_SHORT);
    case (gsel)
      2'd0:    gateLen = TW'(GATE_T0);
      2'd1:    gateLen = TW'(GATE_T1);
      2'd2:    gateLen = TW'(GATE_T2);
      default: gateLen = TW'(GATE_T3);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mode     <= SRC_FAST;
      gsel     <= 2'd0;
      tickCnt  <= '0;
      edgeSeen <= 1'b0;
    end else if (ctrlLatch) begin
      mode     <= selHigh ? SRC_FAST : (selFreq ? SRC_SLOW : SRC_PERIOD);
      gsel     <= gateSel;
      tickCnt  <= '0;
      edgeSeen <= 1'b0;
      state    <= countEn ? ST_WAIT : ST_IDLE;
    end else begin
      case (state)
        ST_WAIT: if (msTick) begin
          if (tickCnt == waitLen - 1'b1) begin
            tickCnt <= '0;
            state   <= (mode == SRC_PERIOD) ? ST_ARM : ST_GATE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_ARM: if (slowRise) state <= ST_GATE;
        ST_GATE: begin
          if (mode == SRC_PERIOD) begin
            if (slowRise) begin
              if (edgeSeen || !twoPeriods) state <= ST_DONE;
              else                         edgeSeen <= 1'b1;
            end
          end else if (msTick) begin
            if (tickCnt == gateLen - 1'b1) state <= ST_DONE;
            else                           tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    dp          = '0;
    dp.clearAll = ctrlLatch & ~countEn;
    dp.restart  = ctrlLatch;
    if (!ctrlLatch && state == ST_GATE) begin
      dp.cntFast = (mode == SRC_FAST);
      dp.cntSlow = (mode == SRC_SLOW);
      dp.cntRef  = (mode == SRC_PERIOD);
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/freq_period_meter.sv
module freq_period_meter
  import fpm_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int WAIT_SHORT = 4,
  parameter int WAIT_LONG  = 8,
  parameter int GATE_T0    = 4,
  parameter int GATE_T1    = 8,
  parameter int GATE_T2    = 32,
  parameter int GATE_T3    = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastIn,
  input  logic             slowIn,
  input  logic             refTick,
  input  logic             msTick,
  input  logic             ctrlLatch,
  input  logic             selHigh,
  input  logic             selFreq,
  input  logic             countEn,
  input  logic [1:0]       gateSel,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             overflow,
  output logic             fastLevel,
  output logic             slowLevel
);

  dpCtrl_t dpStrobes;
  logic    slowRise;

  fpm_control #(
    .WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG),
    .GATE_T0(GATE_T0), .GATE_T1(GATE_T1), .GATE_T2(GATE_T2), .GATE_T3(GATE_T3)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlLatch(ctrlLatch), .selHigh(selHigh),
    .selFreq(selFreq), .countEn(countEn), .gateSel(gateSel), .msTick(msTick),
    .slowRise(slowRise), .dp(dpStrobes), .done(done)
  );

  fpm_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .fastIn(fastIn), .slowIn(slowIn), .refTick(refTick),
    .dp(dpStrobes), .slowRise(slowRise), .count(count), .overflow(overflow),
    .fastLevel(fastLevel), .slowLevel(slowLevel)
  );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlLatch,
  input logic             countEn,
  input logic [CNT_W-1:0] count,
  input logic             done,
  input logic             overflow
);

  logic clearWrite;
  assign clearWrite = ctrlLatch & ~countEn;

  AST_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    clearWrite |=> (count == '0 && !overflow && !done)); // R6

  AST_LATCH_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLatch |=> !done); // R8

  AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ctrlLatch) |=> (done && $stable(count))); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !clearWrite |=> (count >= $past(count))); // R9

  AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (count == {CNT_W{1'b1}})); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clearWrite) |=> overflow); // R9

endmodule

bind freq_period_meter fpm_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .ctrlLatch(ctrlLatch), .countEn(countEn),
  .count(count), .done(done), .overflow(overflow)
);

// File: tb/freq_period_meter_test.sv
module freq_period_meter_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_EVERY = 50;
  localparam int CW         = 8;
  localparam int CMAX       = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic fastIn = 1'b0, slowIn = 1'b0, refTick = 1'b0, msTick = 1'b0;
  logic ctrlLatch = 1'b0, selHigh = 1'b0, selFreq = 1'b0, countEn = 1'b0;
  logic [1:0] gateSel = 2'd0;
  logic [CW-1:0] count;
  logic done, overflow, fastLevel, slowLevel;

  int nChecks = 0, nFail = 0;
  int tickCnt = 0, refCnt = 0, refEvery = 1;

  freq_period_meter #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .fastIn(fastIn), .slowIn(slowIn), .refTick(refTick),
    .msTick(msTick), .ctrlLatch(ctrlLatch), .selHigh(selHigh), .selFreq(selFreq),
    .countEn(countEn), .gateSel(gateSel), .count(count), .done(done),
    .overflow(overflow), .fastLevel(fastLevel), .slowLevel(slowLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICK_EVERY-1) ? 0 : tickCnt + 1;
    msTick  <= (tickCnt == TICK_EVERY-2);
    refCnt  <= (refCnt + 1 >= refEvery) ? 0 : refCnt + 1;
    refTick <= (refCnt == 0);
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    repeat (n) begin
      do @(posedge clk); while (!msTick);
    end
  endtask

  task automatic writeCtl(bit hi, bit fr, bit en, logic [1:0] gs);
    waitTicks(1);
    @(negedge clk);
    selHigh = hi; selFreq = fr; countEn = en; gateSel = gs; ctrlLatch = 1'b1;
    @(negedge clk);
    ctrlLatch = 1'b0;
  endtask

  // mask bit0 drives fastIn, bit1 drives slowIn
  task automatic pulses(logic [1:0] mask, int k);
    repeat (k) begin
      if (mask[0]) fastIn = 1'b1;
      if (mask[1]) slowIn = 1'b1;
      repeat (2) @(negedge clk);
      fastIn = 1'b0; slowIn = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic waitDone(string req);
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, int'(done), 1);
  endtask

  task automatic freqRun(bit fast, logic [1:0] gs, int k);
    int gticks;
    int exp;
    gticks = (gs == 0) ? 4 : (gs == 1) ? 8 : (gs == 2) ? 32 : 64;
    exp    = fast ? k / 2 : k;
    writeCtl(1'b0, 1'b1, 1'b0, 2'd0);
    writeCtl(fast, 1'b1, 1'b1, gs);
    pulses(2'b11, 3);              // R5 edges during the settling wait
    waitTicks(4);
    fork
      begin
        repeat (10) @(negedge clk);
        pulses(2'b11, k);          // R1 both pins pulse, only one is selected
      end
    join_none
    waitTicks(gticks - 1);
    @(negedge clk);
    chk("R3 done low one tick before gate end", int'(done), 0);
    waitTicks(1);
    @(negedge clk);
    chk("R3 done at gate end", int'(done), 1);
    chk(fast ? "R2 fast count halved" : "R1 slow frequency count", int'(count), exp);
    pulses(2'b11, 4);
    chk("R8 count frozen after done", int'(count), exp);
    chk("R8 done held", int'(done), 1);
  endtask

  task automatic periodRun(bit two, int per, int rEvery, int expCnt, int expOvf);
    refEvery = rEvery;
    writeCtl(1'b0, 1'b1, 1'b0, 2'd0);
    writeCtl(1'b0, 1'b0, 1'b1, {1'b0, two});
    waitTicks(two ? 8 : 4);
    repeat (5) @(negedge clk);
    chk("R4 not done while armed", int'(done), 0);
    for (int i = 0; i < (two ? 4 : 3); i++) begin
      slowIn = 1'b1;
      repeat (per / 2) @(negedge clk);
      slowIn = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
    waitDone("R4 period done");
    chk("R4 period count", int'(count), expCnt);
    chk("R9 overflow flag", int'(overflow), expOvf);
    refEvery = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset count", int'(count), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R9 reset overflow", int'(overflow), 0);

    // R10 two-flop level path
    fastIn = 1'b1; slowIn = 1'b1;
    @(negedge clk);
    chk("R10 fast level after one edge", int'(fastLevel), 0);
    chk("R10 slow level after one edge", int'(slowLevel), 0);
    @(negedge clk);
    chk("R10 fast level after two edges", int'(fastLevel), 1);
    chk("R10 slow level after two edges", int'(slowLevel), 1);
    fastIn = 1'b0; slowIn = 1'b0;
    repeat (3) @(negedge clk);

    // frequency sweeps over gate times, inputs and edge counts
    for (int gs = 0; gs < 4; gs++) begin
      for (int f = 0; f < 2; f++) begin
        freqRun(f[0], gs[1:0], 0);
        freqRun(f[0], gs[1:0], 7);
        freqRun(f[0], gs[1:0], 30);
      end
    end

    // period mode, one and two periods, two reference rates
    periodRun(1'b0, 60, 1, 60, 0);
    periodRun(1'b1, 60, 1, 120, 0);
    periodRun(1'b0, 90, 3, 30, 0);
    periodRun(1'b1, 90, 3, 60, 0);
    // R9 saturation boundary
    periodRun(1'b0, CMAX, 1, CMAX, 0);
    periodRun(1'b0, CMAX + 1, 1, CMAX, 1);
    periodRun(1'b1, 150, 1, CMAX, 1);

    // R6 clearing write after overflow
    writeCtl(1'b0, 1'b1, 1'b0, 2'd0);
    chk("R6 count cleared", int'(count), 0);
    chk("R6 overflow cleared", int'(overflow), 0);
    chk("R6 done cleared", int'(done), 0);

    // R7 integrating measurements
    writeCtl(1'b0, 1'b1, 1'b1, 2'd0);
    waitTicks(4);
    repeat (10) @(negedge clk);
    pulses(2'b10, 10);
    waitDone("R7 first done");
    chk("R7 first measurement", int'(count), 10);
    writeCtl(1'b0, 1'b1, 1'b1, 2'd0);
    chk("R8 done dropped by new write", int'(done), 0);
    chk("R7 count kept on restart", int'(count), 10);
    waitTicks(4);
    repeat (10) @(negedge clk);
    pulses(2'b10, 7);
    waitDone("R7 second done");
    chk("R7 accumulated count", int'(count), 17);

    // R11 high level at gate open and falling edge are not counted
    writeCtl(1'b0, 1'b1, 1'b0, 2'd0);
    writeCtl(1'b0, 1'b1, 1'b1, 2'd0);
    repeat (10) @(negedge clk);
    slowIn = 1'b1;
    waitTicks(4);
    repeat (10) @(negedge clk);
    slowIn = 1'b0;
    repeat (4) @(negedge clk);
    pulses(2'b10, 6);
    waitDone("R11 done");
    chk("R11 rising edges only", int'(count), 6);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule